// File: doc/BRIEF.md
# Indexed and Indirect Effective Address Generator

This block forms the 16-bit effective address for the addressing modes of a classic 8-bit processor core. A decoder presents a mode code, an access kind, the one or two operand bytes that follow the opcode, the two index registers and the address of the next instruction. A pulse on `start_i` then runs the calculation. Modes that go through a pointer use a small sequencer. It issues two byte reads on a simple synchronous read port, and each read returns its data one cycle after the request.

The result is a one-cycle `done_o` pulse with the address on `ea_o` and an extra-cycle count on `extra_o`. An indexed read that crosses into the next page costs one cycle. A taken relative branch costs one cycle, or two when its target lies in another page. Every pointer fetch keeps its second byte in the same 256-byte page as the first. This gives zero-page wraparound for the indirect modes and the known indirect-jump quirk when the pointer's low byte is 0xFF.

Top module: `eff_addr_unit`

## Requirements
- R1: Modes 1 (zero page), 2 (zero page + X) and 3 (zero page + Y) give `ea_o = {8'h00, (op_lo_i + index) mod 256}`, with index 0, X and Y respectively, and `extra_o = 0`.
- R2: Modes 0 (absolute), 4 (absolute + X) and 5 (absolute + Y) give `ea_o = ({op_hi_i, op_lo_i} + index) mod 65536`, with index 0, X and Y respectively.
- R3: Mode 6 (pre-indexed indirect) reads the pointer low byte at `{8'h00, op_lo_i + X}` and the high byte at the next zero-page address, wrapping from 0xFF to 0x00. It gives `ea_o = {hi, lo}`.
- R4: Mode 7 (post-indexed indirect) reads the pointer at `{8'h00, op_lo_i}` and at the next zero-page address, wrapping. It gives `ea_o = ({hi, lo} + Y) mod 65536`.
- R5: Mode 8 (indirect jump) reads the low byte at `{op_hi_i, op_lo_i}`. It reads the high byte at `{op_hi_i, op_lo_i + 1}`, so a low byte of 0xFF fetches the high byte from `{op_hi_i, 8'h00}`.
- R6: In modes 4, 5 and 7 with access kind 0 (read), `extra_o = 1` exactly when the low byte of `ea_o` is below the index used. Modes 0, 1, 2, 3, 6 and 8 always give `extra_o = 0`.
- R7: In every mode other than 9, access kind 1 (write) or 2 (read-modify-write) gives `extra_o = 0`.
- R8: Mode 9 (relative branch) with `taken_i = 0` gives `ea_o = next_pc_i` and `extra_o = 0`. With `taken_i = 1` it gives `ea_o = next_pc_i + sign-extended op_lo_i` and `extra_o = 1`, or `2` when the upper byte of the target differs from that of `next_pc_i`.
- R9: `done_o` is a one-cycle pulse. It comes one cycle after the start cycle in modes 0 to 5 and 9, and no reads are issued in those modes. In modes 6 to 8 exactly two reads are issued on the two cycles after the start cycle, and `done_o` follows one cycle after the second read's data returns.
- R10: During and right after reset, `done_o`, `mem_rd_o`, `ea_o` and `extra_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation; accepted only when idle |
| mode_i | input | 4 | Addressing mode code (0 to 9) |
| access_i | input | 2 | Access kind: 0 read, 1 write, 2 read-modify-write |
| op_lo_i | input | 8 | First operand byte (zero-page address, low address byte or branch offset) |
| op_hi_i | input | 8 | Second operand byte (high address byte) |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| next_pc_i | input | 16 | Address of the following instruction |
| taken_i | input | 1 | Branch condition is true |
| mem_rd_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 16 | Pointer byte read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective address, held until the next result |
| extra_o | output | 2 | Extra cycles for page crossing or taken branch |

## Verification
The assertions assume that `start_i` is raised only while the block is idle. They also assume that the read port returns data exactly one cycle after each request. The bench therefore waits for `done_o` before it starts the next operation, and it models the memory as a registered lookup of a fixed address-to-byte function. The assertions also take `mode_i` to be one of the ten defined codes, and every vector keeps to those codes. The pointer checks depend on the two reads being back to back. This holds because the stimulus never interleaves operations.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    M_ABS  = 4'd0,
    M_ZP   = 4'd1,
    M_ZPX  = 4'd2,
    M_ZPY  = 4'd3,
    M_ABSX = 4'd4,
    M_ABSY = 4'd5,
    M_INDX = 4'd6,
    M_INDY = 4'd7,
    M_IND  = 4'd8,
    M_REL  = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RMW   = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PTR_LO,
    S_PTR_HI,
    S_CALC
  } seq_e;

  function automatic logic needs_ptr(mode_e m);
    return m inside {M_INDX, M_INDY, M_IND};
  endfunction

  function automatic logic is_zp(mode_e m);
    return m inside {M_ZP, M_ZPX, M_ZPY};
  endfunction

  function automatic logic can_cross(mode_e m);
    return m inside {M_ABSX, M_ABSY, M_INDY};
  endfunction
endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] idx_i,
  output logic [AW-1:0] sum_o,
  output logic          crossed_o
);
  localparam int PW = AW - DW;

  assign sum_o     = base_i + {{PW{1'b0}}, idx_i};
  // low byte wrapped below the index => carry into the page byte
  assign crossed_o = sum_o[DW-1:0] < idx_i;
endmodule

// File: rtl/eag_branch.sv
module eag_branch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] off_i,
  input  logic          taken_i,
  output logic [AW-1:0] target_o,
  output logic [1:0]    extra_o
);
  localparam int PW = AW - DW;

  logic [AW-1:0] jump;
  logic          page_chg;

  assign jump     = pc_i + {{PW{off_i[DW-1]}}, off_i};
  assign page_chg = jump[AW-1:DW] != pc_i[AW-1:DW];
  assign target_o = taken_i ? jump : pc_i;
  assign extra_o  = !taken_i ? 2'd0 : (page_chg ? 2'd2 : 2'd1);
endmodule

// File: rtl/eag_ptr_seq.sv
module eag_ptr_seq
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          need_ptr_i,
  input  logic [AW-1:0] ptr_addr_i,
  output seq_e          state_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = need_ptr_i ? S_PTR_LO : S_CALC;
      S_PTR_LO: state_d = S_PTR_HI;
      S_PTR_HI: state_d = S_CALC;
      S_CALC:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign mem_rd_o = (state_q == S_PTR_LO) || (state_q == S_PTR_HI);
  // second byte stays in the pointer's page: zp wrap and jump quirk
  assign mem_addr_o = (state_q == S_PTR_HI)
                    ? {ptr_addr_i[AW-1:DW], ptr_addr_i[DW-1:0] + 1'b1}
                    : ptr_addr_i;
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    access_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] idx_x_i,
  input  logic [DW-1:0] idx_y_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          taken_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic [1:0]    extra_o
);
  localparam int PW = AW - DW;

  mode_e         mode_q;
  acc_e          acc_q;
  logic [DW-1:0] lo_q, hi_q, x_q, y_q, ptr_lo_q;
  logic [AW-1:0] pc_q;
  logic          tk_q;
  seq_e          state;
  logic          accept;
  logic [AW-1:0] ptr_addr, base, add_base, sum, br_target, ea_d;
  logic [DW-1:0] idx;
  logic          crossed;
  logic [1:0]    br_extra, extra_d;

  assign accept = start_i && (state == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_ABS;
      acc_q  <= ACC_READ;
      lo_q   <= '0;
      hi_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      pc_q   <= '0;
      tk_q   <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_e'(mode_i);
      acc_q  <= acc_e'(access_i);
      lo_q   <= op_lo_i;
      hi_q   <= op_hi_i;
      x_q    <= idx_x_i;
      y_q    <= idx_y_i;
      pc_q   <= next_pc_i;
      tk_q   <= taken_i;
    end
  end

  always_comb begin
    unique case (mode_q)
      M_INDX:  ptr_addr = {{PW{1'b0}}, lo_q + x_q};
      M_INDY:  ptr_addr = {{PW{1'b0}}, lo_q};
      default: ptr_addr = {hi_q, lo_q};
    endcase
  end

  eag_ptr_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .need_ptr_i (needs_ptr(mode_e'(mode_i))),
    .ptr_addr_i (ptr_addr),
    .state_o    (state),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o)
  );

  // pointer low byte arrives while the high byte is being requested
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_lo_q <= '0;
    else if (state == S_PTR_HI)  ptr_lo_q <= mem_rdata_i;
  end

  always_comb begin
    unique case (mode_q)
      M_ZPX, M_ABSX:         idx = x_q;
      M_ZPY, M_ABSY, M_INDY: idx = y_q;
      default:               idx = '0;
    endcase
  end

  assign base     = needs_ptr(mode_q) ? {mem_rdata_i, ptr_lo_q} : {hi_q, lo_q};
  assign add_base = is_zp(mode_q) ? {{PW{1'b0}}, lo_q} : base;

  eag_index_add #(.AW(AW), .DW(DW)) u_add (
    .base_i    (add_base),
    .idx_i     (idx),
    .sum_o     (sum),
    .crossed_o (crossed)
  );

  eag_branch #(.AW(AW), .DW(DW)) u_br (
    .pc_i     (pc_q),
    .off_i    (lo_q),
    .taken_i  (tk_q),
    .target_o (br_target),
    .extra_o  (br_extra)
  );

  always_comb begin
    if (mode_q == M_REL) begin
      ea_d    = br_target;
      extra_d = br_extra;
    end else begin
      ea_d    = is_zp(mode_q) ? {{PW{1'b0}}, sum[DW-1:0]} : sum;
      extra_d = {1'b0, can_cross(mode_q) && (acc_q == ACC_READ) && crossed};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      ea_o    <= '0;
      extra_o <= '0;
    end else begin
      done_o <= (state == S_CALC);
      if (state == S_CALC) begin
        ea_o    <= ea_d;
        extra_o <= extra_d;
      end
    end
  end
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] ea_o,
  input logic [1:0]    extra_o,
  input mode_e         mode_q,
  input acc_e          acc_q
);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_read_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_rd_o);

  // R3 R4 R5: second pointer read is the next byte of the same page
  assert_ptr_same_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |->
      (mem_addr_o[AW-1:DW] == $past(mem_addr_o[AW-1:DW])) &&
      (mem_addr_o[DW-1:0] == DW'($past(mem_addr_o[DW-1:0]) + 1'b1)));

  assert_zp_page_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_zp(mode_q)) |-> (ea_o[AW-1:DW] == '0));

  assert_no_penalty_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (acc_q != ACC_READ) && (mode_q != M_REL)) |-> (extra_o == 2'd0));

  assert_no_penalty_unindexed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_q inside {M_ABS, M_ZP, M_ZPX, M_ZPY, M_INDX, M_IND})) |-> (extra_o == 2'd0));

  assert_branch_extra_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_q == M_REL)) |-> (extra_o != 2'd3));
endmodule

bind eff_addr_unit eff_addr_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .ea_o       (ea_o),
  .extra_o    (extra_o),
  .mode_q     (mode_q),
  .acc_q      (acc_q)
);

// File: tb/eff_addr_unit_tb_top.sv
module eff_addr_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  access_i = '0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, idx_x_i = '0, idx_y_i = '0;
  logic [15:0] next_pc_i = '0;
  logic        taken_i = 1'b0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        done_o;
  logic [15:0] ea_o;
  logic [1:0]  extra_o;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;

  always #4 clk_i = ~clk_i;

  eff_addr_unit dut_i (.*);

  function automatic logic [7:0] mem_fn(logic [15:0] a);
    return 8'(a[7:0] + 8'(a[15:8] * 8'd7) + 8'h11);
  endfunction

  // registered read port, data one cycle after the request
  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      mem_rdata_i <= mem_fn(mem_addr_o);
      rd_cnt      <= rd_cnt + 1;
    end
  end

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  acc;
    logic [7:0]  lo, hi, x, y;
    logic [15:0] pc;
    logic        tk;
    logic [15:0] ea;
    logic [1:0]  ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'd0, 8'h42, 8'h77, 8'h10, 8'h20, 16'h0, 1'b0, 16'h0042, 2'd0, 4'd1},  // R1
    '{4'd2, 2'd0, 8'hF0, 8'h77, 8'h20, 8'h00, 16'h0, 1'b0, 16'h0010, 2'd0, 4'd1},  // R1 wrap
    '{4'd3, 2'd0, 8'h80, 8'h00, 8'h99, 8'h05, 16'h0, 1'b0, 16'h0085, 2'd0, 4'd1},  // R1
    '{4'd2, 2'd1, 8'hFF, 8'h00, 8'hFF, 8'h00, 16'h0, 1'b0, 16'h00FE, 2'd0, 4'd1},  // R1
    '{4'd0, 2'd0, 8'h34, 8'h12, 8'h55, 8'h66, 16'h0, 1'b0, 16'h1234, 2'd0, 4'd2},  // R2
    '{4'd5, 2'd0, 8'hFF, 8'hFF, 8'h00, 8'h02, 16'h0, 1'b0, 16'h0001, 2'd1, 4'd2},  // R2 wrap
    '{4'd4, 2'd0, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0, 16'h1310, 2'd1, 4'd6},  // R6
    '{4'd5, 2'd0, 8'h10, 8'h12, 8'h00, 8'h20, 16'h0, 1'b0, 16'h1230, 2'd0, 4'd6},  // R6
    '{4'd4, 2'd0, 8'h00, 8'h40, 8'h00, 8'h00, 16'h0, 1'b0, 16'h4000, 2'd0, 4'd6},  // R6
    '{4'd4, 2'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0, 16'h1310, 2'd0, 4'd7},  // R7
    '{4'd5, 2'd2, 8'hFF, 8'hFF, 8'h00, 8'h02, 16'h0, 1'b0, 16'h0001, 2'd0, 4'd7},  // R7
    '{4'd9, 2'd0, 8'h10, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b0, 16'h2000, 2'd0, 4'd8},  // R8
    '{4'd9, 2'd0, 8'h10, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b1, 16'h2010, 2'd1, 4'd8},  // R8
    '{4'd9, 2'd1, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h2005, 1'b1, 16'h1FF5, 2'd2, 4'd8},  // R8
    '{4'd9, 2'd0, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h20F0, 1'b1, 16'h216F, 2'd2, 4'd8}   // R8
  };

  task automatic chk(input logic ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one operation; returns cycles from start to done and reads issued
  task automatic run(input logic [3:0] m, input logic [1:0] a, input logic [7:0] lo, hi, x, y,
                     input logic [15:0] pc, input logic tk, output int lat, output int rds);
    @(negedge clk_i);
    mode_i = m; access_i = a; op_lo_i = lo; op_hi_i = hi;
    idx_x_i = x; idx_y_i = y; next_pc_i = pc; taken_i = tk;
    rd_cnt = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    rds = rd_cnt;
  endtask

  task automatic ptr_case(input logic [3:0] m, input logic [1:0] a, input logic [7:0] lo, hi, x, y,
                          input int req);
    logic [15:0] p0, p1, e;
    logic [1:0]  ex;
    int lat, rds;
    // reference from the requirements (R3, R4, R5)
    if (m == 4'd6)      p0 = {8'h00, 8'(lo + x)};
    else if (m == 4'd7) p0 = {8'h00, lo};
    else                p0 = {hi, lo};
    p1 = {p0[15:8], 8'(p0[7:0] + 8'd1)};
    e  = {mem_fn(p1), mem_fn(p0)};
    ex = 2'd0;
    if (m == 4'd7) begin
      e = e + {8'h00, y};
      ex = {1'b0, (a == 2'd0) && (e[7:0] < y)};
    end
    run(m, a, lo, hi, x, y, 16'h0, 1'b0, lat, rds);
    chk(ea_o == e, req, "pointer ea", 32'(ea_o), 32'(e));
    chk(extra_o == ex, req, "pointer extra", 32'(extra_o), 32'(ex));
    chk(lat == 4 && rds == 2, 9, "pointer latency/reads", 32'(lat * 16 + rds), 32'(4 * 16 + 2)); // R9
  endtask

  initial begin
    int lat, rds;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!done_o && !mem_rd_o && ea_o == 16'h0 && extra_o == 2'd0, 10, "reset outputs",
        32'({done_o, mem_rd_o, extra_o, ea_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !mem_rd_o && ea_o == 16'h0, 10, "after reset", 32'({done_o, mem_rd_o, ea_o}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].mode, VECS[i].acc, VECS[i].lo, VECS[i].hi, VECS[i].x, VECS[i].y,
          VECS[i].pc, VECS[i].tk, lat, rds);
      chk(ea_o == VECS[i].ea, int'(VECS[i].req), $sformatf("vec %0d ea", i), 32'(ea_o), 32'(VECS[i].ea));
      chk(extra_o == VECS[i].ex, int'(VECS[i].req), $sformatf("vec %0d extra", i),
          32'(extra_o), 32'(VECS[i].ex));
      chk(lat == 2 && rds == 0, 9, $sformatf("vec %0d latency/reads", i), // R9
          32'(lat * 16 + rds), 32'(2 * 16));
      @(negedge clk_i);
      chk(!done_o, 9, "done single pulse", 32'(done_o), 32'h0); // R9
    end

    ptr_case(4'd6, 2'd0, 8'h80, 8'h00, 8'h05, 8'h00, 3);  // R3
    ptr_case(4'd6, 2'd0, 8'hFE, 8'h00, 8'h01, 8'h00, 3);  // R3 pointer at 0xFF wraps
    ptr_case(4'd7, 2'd0, 8'h40, 8'h00, 8'h00, 8'hF0, 4);  // R4 with page cross
    ptr_case(4'd7, 2'd0, 8'hFF, 8'h00, 8'h00, 8'h10, 4);  // R4 zp wrap
    ptr_case(4'd7, 2'd1, 8'h40, 8'h00, 8'h00, 8'hF0, 7);  // R7 store, no penalty
    ptr_case(4'd8, 2'd0, 8'h34, 8'h12, 8'h00, 8'h00, 5);  // R5 normal
    ptr_case(4'd8, 2'd0, 8'hFF, 8'h12, 8'h00, 8'h00, 5);  // R5 page quirk
    // R5 explicit value: lo from 0x12FF = 0x8E, hi from 0x1200 = 0x8F
    chk(ea_o == 16'h8F8E, 5, "jump quirk literal", 32'(ea_o), 32'h8F8E);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired: actual %0d expected done", n_chk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule